// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches the demodulated output of an infrared receiver module and records the message it carries as a list of durations. Each duration is the length of one pulse (carrier present) or one space (carrier absent), counted in units of a programmable sample period. The durations go into a capture buffer of 68 byte-wide entries. The buffer is read as 17 words of 32 bits, four entries to a word. The first entry is always a pulse, and after that the entries alternate between space and pulse.

Capture ends when a space lasts 255 sample periods or when all 68 entries are full. At that point the receiver stops and keeps the buffer unchanged. It sets an interrupt status bit. Software reads the words over a small register bus and decodes the protocol itself. It then writes a restart command, which clears the buffer and arms the receiver for the next message. It also writes an acknowledge, which clears the interrupt status. Capture runs only while both the receiver enable and the width-detection enable are set.

Top module: `irrx_capture`

## Requirements
- R1: After reset, `irq_o` is low and every buffer word reads zero. The enable register (offset 0x0C) reads zero. The period register (offset 0x10) reads 0x000C0000, which is a sample period of 0xC00 clock cycles held in bits 20:8.
- R2: The sample period in clock cycles is set by bits 20:8 of offset 0x10. A value of 0 acts as 1. Each entry is the number of sample ticks during which the line held one level. The first entry is a pulse, and entries then alternate between space and pulse.
- R3: Entry 4*i+j sits in bits 8j+7:8j of buffer word i. Word i reads at offset 0x88+4*i, for i from 0 to 16.
- R4: A pulse longer than 255 sample periods is stored as 255. Capture continues with the space that follows it.
- R5: When a space reaches 255 sample periods, the value 255 is stored and the message ends. Capture then freezes, and later activity on the input leaves the buffer unchanged.
- R6: After the 68th entry is stored, capture freezes, and later input changes no entry.
- R7: Capture runs only while bit 0 and bit 13 of offset 0x0C are both 1. With either bit clear, no entry is written and no interrupt status is raised.
- R8: Writing 1 to bit 0 of offset 0x20 clears all 68 entries to zero. It also arms the receiver, which then waits for the input to become active before the first entry starts.
- R9: The interrupt status is set when a message ends or the buffer fills. `irq_o` equals the status ANDed with the enable in bit 0 of offset 0xCC. Writing 1 to bit 0 of offset 0xD0 clears the status. If a new end event and the clear arrive in the same cycle, the status stays set.
- R10: Entries that a message did not write read back as zero.
- R11: `ir_rx_i` is active low, so a low level is a pulse. It passes through a two-flop synchroniser, and its level is sampled only on sample-period ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_i | input | 1 | Demodulated infrared line, low while carrier is present |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not selected |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The main capture path is run with three-segment messages (pulse, space, pulse) followed by a long idle. The durations and sample periods vary across runs, and one run uses a period of zero. A wrong tick count, a reversed lane order or a misplaced trailing 255 each shows up as a different byte in word 0. A single pulse of 300 periods shows whether a width saturates or wraps. A message of 69 short segments fills the buffer, which exposes an off-by-one at the last index and confirms that the first and last words are filled. Input played after a freeze, input played with only one enable set, and interrupt enable toggled after the event each show whether a gate is missing, because the buffer or `irq_o` then changes when it should not.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned BUS_DW  = 32;
  localparam int unsigned ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PERIOD  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RESTART = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_BUF     = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 8'hCC;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 8'hD0;

  localparam int unsigned RX_EN_BIT  = 0;
  localparam int unsigned PW_EN_BIT  = 13;
  localparam int unsigned PER_LSB    = 8;

  localparam logic [LANE_W-1:0] WIDTH_MAX = 8'hFF;

  typedef enum logic [1:0] {
    CAP_ARMED = 2'd0,
    CAP_RUN   = 2'd1,
    CAP_HALT  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/irrx_prescaler.sv
module irrx_prescaler #(
  parameter int unsigned PERIOD_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                restart_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] cnt_d;
  logic [PERIOD_W-1:0] limit;

  always_comb begin
    limit  = (period_i == '0) ? '0 : period_i - 1'b1;
    tick_o = run_i && (cnt_q >= limit);
    if (!run_i || restart_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irrx_width_engine.sv
module irrx_width_engine
  import irrx_pkg::*;
#(
  parameter int unsigned ENTRIES       = 68,
  parameter int unsigned IDX_W         = 7,
  parameter bit          RX_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              restart_i,
  output logic              we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LANE_W-1:0] data_o,
  output logic              done_evt_o
);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [LANE_W-1:0] NEAR_MAX = WIDTH_MAX - 1'b1;

  logic              sync1_q, sync2_q;
  logic              active;
  cap_state_e        st_q, st_d;
  logic              pol_q, pol_d;
  logic [LANE_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  // two-flop synchroniser, idle level out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= RX_ACTIVE_LOW;
      sync2_q <= RX_ACTIVE_LOW;
    end else begin
      sync1_q <= rx_i;
      sync2_q <= sync1_q;
    end
  end

  assign active = sync2_q ^ RX_ACTIVE_LOW;

  always_comb begin
    st_d       = st_q;
    pol_d      = pol_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    we_o       = 1'b0;
    data_o     = cnt_q;
    done_evt_o = 1'b0;
    if (restart_i) begin
      st_d  = CAP_ARMED;
      pol_d = 1'b0;
      cnt_d = '0;
      idx_d = '0;
    end else if (tick_i) begin
      unique case (st_q)
        CAP_ARMED: begin
          if (active) begin
            st_d  = CAP_RUN;
            pol_d = 1'b1;
            cnt_d = 8'd1;
            idx_d = '0;
          end
        end
        CAP_RUN: begin
          if (active == pol_q) begin
            if (cnt_q != WIDTH_MAX) cnt_d = cnt_q + 1'b1;
            if (!pol_q && (cnt_q == NEAR_MAX)) begin
              we_o       = 1'b1;
              data_o     = WIDTH_MAX;
              done_evt_o = 1'b1;
              st_d       = CAP_HALT;
            end
          end else begin
            we_o = 1'b1;
            if (idx_q == LAST_IDX) begin
              done_evt_o = 1'b1;
              st_d       = CAP_HALT;
            end else begin
              idx_d = idx_q + 1'b1;
              pol_d = active;
              cnt_d = 8'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CAP_ARMED;
      pol_q <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      pol_q <= pol_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/irrx_capbuf.sv
module irrx_capbuf
  import irrx_pkg::*;
#(
  parameter int unsigned ENTRIES = 68,
  parameter int unsigned IDX_W   = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [LANE_W-1:0]         data_i,
  output logic [ENTRIES*LANE_W-1:0] flat_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [LANE_W-1:0] ent_q;
    logic [LANE_W-1:0] ent_d;
    logic              ent_en;

    always_comb begin
      ent_en = clear_i || (we_i && (idx_i == IDX_W'(e)));
      ent_d  = clear_i ? '0 : data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign flat_o[e*LANE_W +: LANE_W] = ent_q;
  end
endmodule

// File: rtl/irrx_capture.sv
module irrx_capture
  import irrx_pkg::*;
#(
  parameter int unsigned WORDS         = 17,
  parameter int unsigned PERIOD_W      = 13,
  parameter bit          RX_ACTIVE_LOW = 1'b1,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = 13'hC00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_rx_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  localparam int unsigned ENTRIES = WORDS * LANES;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned FLAT_W  = ENTRIES * LANE_W;
  localparam logic [5:0]  WORDS_L = 6'(WORDS);

  logic                rx_en_q, rx_en_d;
  logic                pw_en_q, pw_en_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                ien_q, ien_d;
  logic                status_q, status_d;

  logic                wr;
  logic                restart;
  logic                ack;
  logic                run;
  logic                tick;
  logic                buf_we;
  logic [IDX_W-1:0]    buf_idx;
  logic [LANE_W-1:0]   buf_data;
  logic                done_evt;
  logic [FLAT_W-1:0]   buf_flat;

  logic [ADDR_W-1:0]   buf_off;
  logic                buf_hit;

  assign wr      = bus_sel_i && bus_wr_i;
  assign restart = wr && (bus_addr_i == OFS_RESTART) && bus_wdata_i[0];
  assign ack     = wr && (bus_addr_i == OFS_ACK) && bus_wdata_i[0];
  assign run     = rx_en_q && pw_en_q;

  irrx_prescaler #(.PERIOD_W(PERIOD_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (restart),
    .period_i  (period_q),
    .tick_o    (tick)
  );

  irrx_width_engine #(
    .ENTRIES       (ENTRIES),
    .IDX_W         (IDX_W),
    .RX_ACTIVE_LOW (RX_ACTIVE_LOW)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (ir_rx_i),
    .tick_i     (tick),
    .restart_i  (restart),
    .we_o       (buf_we),
    .idx_o      (buf_idx),
    .data_o     (buf_data),
    .done_evt_o (done_evt)
  );

  irrx_capbuf #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (restart),
    .we_i    (buf_we),
    .idx_i   (buf_idx),
    .data_i  (buf_data),
    .flat_o  (buf_flat)
  );

  // register file next state
  always_comb begin
    rx_en_d  = rx_en_q;
    pw_en_d  = pw_en_q;
    period_d = period_q;
    ien_d    = ien_q;
    if (wr && (bus_addr_i == OFS_ENABLE)) begin
      rx_en_d = bus_wdata_i[RX_EN_BIT];
      pw_en_d = bus_wdata_i[PW_EN_BIT];
    end
    if (wr && (bus_addr_i == OFS_PERIOD)) begin
      period_d = bus_wdata_i[PER_LSB +: PERIOD_W];
    end
    if (wr && (bus_addr_i == OFS_IEN)) begin
      ien_d = bus_wdata_i[0];
    end
    if (done_evt) begin
      status_d = 1'b1;
    end else if (ack) begin
      status_d = 1'b0;
    end else begin
      status_d = status_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      pw_en_q  <= 1'b0;
      period_q <= PERIOD_RST;
      ien_q    <= 1'b0;
      status_q <= 1'b0;
    end else begin
      rx_en_q  <= rx_en_d;
      pw_en_q  <= pw_en_d;
      period_q <= period_d;
      ien_q    <= ien_d;
      status_q <= status_d;
    end
  end

  assign irq_o = status_q && ien_q;

  // read path
  always_comb begin
    buf_off     = bus_addr_i - OFS_BUF;
    buf_hit     = (bus_addr_i >= OFS_BUF) && (buf_off[7:2] < WORDS_L) &&
                  (buf_off[1:0] == 2'b00);
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      if (bus_addr_i == OFS_ENABLE) begin
        bus_rdata_o[RX_EN_BIT] = rx_en_q;
        bus_rdata_o[PW_EN_BIT] = pw_en_q;
      end else if (bus_addr_i == OFS_PERIOD) begin
        bus_rdata_o[PER_LSB +: PERIOD_W] = period_q;
      end else if (bus_addr_i == OFS_IEN) begin
        bus_rdata_o[0] = ien_q;
      end else if (buf_hit) begin
        for (int w = 0; w < WORDS; w++) begin
          if (buf_off[7:2] == 6'(w)) begin
            bus_rdata_o = buf_flat[w*BUS_DW +: BUS_DW];
          end
        end
      end
    end
  end
endmodule

// File: rtl/irrx_capture_chk.sv
module irrx_capture_chk #(
  parameter int unsigned ENTRIES = 68,
  parameter int unsigned IDX_W   = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel_i,
  input logic                 bus_wr_i,
  input logic [7:0]           bus_addr_i,
  input logic [31:0]          bus_wdata_i,
  input logic                 irq_o,
  input logic                 ien_q,
  input logic                 run,
  input logic                 tick,
  input logic                 buf_we,
  input logic [IDX_W-1:0]     buf_idx,
  input logic                 done_evt,
  input logic                 restart,
  input logic [ENTRIES*8-1:0] buf_flat
);
  logic ack_wr, ien_wr;
  assign ack_wr = bus_sel_i && bus_wr_i && (bus_addr_i == 8'hD0) && bus_wdata_i[0];
  assign ien_wr = bus_sel_i && bus_wr_i && (bus_addr_i == 8'hCC);

  p_tick_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  p_write_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> run);

  p_index_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_idx < IDX_W'(ENTRIES)));

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (buf_flat == '0));

  p_freeze_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !buf_we);

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ien_q);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !done_evt) |=> !irq_o);

  p_event_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && ien_q && !ien_wr) |=> irq_o);
endmodule

bind irrx_capture irrx_capture_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .ien_q       (ien_q),
  .run         (run),
  .tick        (tick),
  .buf_we      (buf_we),
  .buf_idx     (buf_idx),
  .done_evt    (done_evt),
  .restart     (restart),
  .buf_flat    (buf_flat)
);

// File: tb/tb_irrx_capture.sv
`timescale 1ns/1ps
module tb_irrx_capture;
  logic        clk;
  logic        rst_n;
  logic        ir_n;
  logic        sel;
  logic        wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int total;
  int fails;
  int per_eff;
  bit finished;

  irrx_capture dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ir_rx_i     (ir_n),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // period[36:24], first pulse[23:16], space[15:8], second pulse[7:0]
  localparam logic [36:0] VEC [6] = '{
    {13'd4, 8'd3,  8'd5,  8'd1},
    {13'd4, 8'd1,  8'd1,  8'd1},
    {13'd6, 8'd2,  8'd9,  8'd4},
    {13'd3, 8'd10, 8'd2,  8'd7},
    {13'd1, 8'd20, 8'd40, 8'd6},
    {13'd0, 8'd5,  8'd3,  8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic seg(input bit act, input int n);
    ir_n = ~act;
    repeat (n * per_eff) @(negedge clk);
  endtask

  task automatic set_period(input int p);
    bwr(8'h10, 32'(p) << 8);
    per_eff = (p == 0) ? 1 : p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] w0_keep;
    total = 0; fails = 0; finished = 0; per_eff = 4;
    ir_n = 1'b1; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    brd(8'h0C, rd); chk("R1 enables", rd, 32'h0);
    brd(8'h10, rd); chk("R1 period", rd, 32'h000C_0000);
    brd(8'h88, rd); chk("R1 word0", rd, 32'h0);
    brd(8'hC8, rd); chk("R1 word16", rd, 32'h0);

    // R7 only receiver enable set: nothing captured
    bwr(8'hCC, 32'h1);
    set_period(4);
    bwr(8'h0C, 32'h0000_0001);
    bwr(8'h20, 32'h1);
    seg(1, 3); seg(0, 3); seg(1, 3); ir_n = 1'b1;
    repeat (300 * 4) @(negedge clk);
    chk("R7 irq stays low", {31'b0, irq}, 32'h0);
    brd(8'h88, rd); chk("R7 no entries", rd, 32'h0);

    bwr(8'h0C, 32'h0000_2001);

    // R2 R3 R10 R11 table-driven messages
    for (int v = 0; v < 6; v++) begin
      logic [12:0] p;
      logic [7:0]  d0, d1, d2;
      p  = VEC[v][36:24];
      d0 = VEC[v][23:16];
      d1 = VEC[v][15:8];
      d2 = VEC[v][7:0];
      set_period(int'(p));
      bwr(8'h20, 32'h1);
      bwr(8'hD0, 32'h1);
      seg(1, int'(d0)); seg(0, int'(d1)); seg(1, int'(d2));
      ir_n = 1'b1;
      repeat (256 * per_eff + 8) @(negedge clk);
      chk("R9 irq on message end", {31'b0, irq}, 32'h1);
      brd(8'h88, rd); chk("R2 R3 R11 word0 widths", rd, {8'hFF, d2, d1, d0});
      brd(8'h8C, rd); chk("R10 word1 unwritten", rd, 32'h0);
    end

    // R4 pulse saturation, R5 end marker
    set_period(4);
    bwr(8'h20, 32'h1);
    bwr(8'hD0, 32'h1);
    chk("R9 ack clears irq", {31'b0, irq}, 32'h0);
    seg(1, 300); seg(0, 3); seg(1, 1); ir_n = 1'b1;
    repeat (256 * 4 + 8) @(negedge clk);
    brd(8'h88, rd); chk("R4 saturated pulse", rd, 32'hFF01_03FF);
    // R5 frozen after end of message
    seg(1, 5); seg(0, 5); seg(1, 5); ir_n = 1'b1;
    repeat (20) @(negedge clk);
    brd(8'h88, rd); chk("R5 word0 frozen", rd, 32'hFF01_03FF);
    brd(8'h8C, rd); chk("R5 word1 frozen", rd, 32'h0);

    // R9 enable gating
    bwr(8'hCC, 32'h0);
    bwr(8'h20, 32'h1);
    bwr(8'hD0, 32'h1);
    seg(1, 2); seg(0, 2); seg(1, 2); ir_n = 1'b1;
    repeat (256 * 4 + 8) @(negedge clk);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    bwr(8'hCC, 32'h1);
    chk("R9 status held then unmasked", {31'b0, irq}, 32'h1);
    bwr(8'hD0, 32'h1);
    chk("R9 ack", {31'b0, irq}, 32'h0);

    // R6 buffer full after 68 entries
    bwr(8'h20, 32'h1);
    for (int s = 0; s < 69; s++) seg((s % 2) == 0, 2);
    ir_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 irq on full", {31'b0, irq}, 32'h1);
    brd(8'h88, rd); chk("R6 word0", rd, 32'h0202_0202);
    brd(8'hC8, rd); chk("R6 word16", rd, 32'h0202_0202);
    w0_keep = rd;
    seg(1, 7); seg(0, 3); seg(1, 4); ir_n = 1'b1;
    repeat (10) @(negedge clk);
    brd(8'hC8, rd); chk("R6 word16 frozen", rd, w0_keep);
    brd(8'h88, rd); chk("R6 word0 frozen", rd, 32'h0202_0202);

    // R8 restart clears every entry
    bwr(8'h20, 32'h1);
    brd(8'h88, rd); chk("R8 word0 cleared", rd, 32'h0);
    brd(8'hA8, rd); chk("R8 word8 cleared", rd, 32'h0);
    brd(8'hC8, rd); chk("R8 word16 cleared", rd, 32'h0);
    // R8 armed: waits for active level, idle line leaves buffer empty
    repeat (300 * 4) @(negedge clk);
    brd(8'h88, rd); chk("R8 armed waits", rd, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule